// File: doc/BRIEF.md
# PTP Fine-Adjust System Time Counter

This block keeps a precision time value as a 32-bit seconds count and a 32-bit sub-second count, clocked by a free-running reference clock. The counting rate is set by a fractional accumulator. Every cycle a 32-bit accumulator adds a programmed rate word to itself. On each carry out of that addition, the sub-second count advances by a programmed step size. Software trims the frequency by adjusting the rate word. The usual setting makes the step twice the clock period and puts the rate word near 2^31, so the accumulator carries on every second cycle.

A small write port programs three configuration registers: the rate word, the step size and the rollover unit. In nanosecond mode the sub-second count is in 1 ns units and rolls over after 999,999,999. In binary mode each unit is about 0.465 ns and the count rolls over after 0x7FFFFFFF. Two single-cycle strobes act on the running time. The load strobe replaces the time with a given value. The adjust strobe adds or subtracts a given seconds and sub-second amount. The current time is presented on two output buses.

Top module: `ptp_fine_clock`

## Requirements
- R1: After reset, seconds and sub-seconds read zero. The rate word, step size and mode are cleared: rate word 0, step 0, mode binary (0). With rate word zero, the time stays at zero.
- R2: When the accumulator carries and no strobe is active, the sub-second count grows by the step size. With rate word 0x80000000, every two clock cycles give exactly one step.
- R3: In a cycle with no carry and no strobe, seconds and sub-seconds do not change.
- R4: With the mode register at 1 (nanosecond), a sub-second sum above 999,999,999 wraps. It becomes sum − 1,000,000,000 and seconds increment by one.
- R5: With the mode register at 0 (binary), a sub-second sum above 0x7FFFFFFF wraps. It becomes sum − 0x80000000 and seconds increment by one.
- R6: A load strobe (init_stb) sets seconds to cmd_sec and sub-seconds to cmd_sub at the next clock edge.
- R7: An adjust strobe with adj_neg=0 adds cmd_sec and cmd_sub to the time. A sub-second overflow past the active limit wraps as in R4/R5 and adds one more second.
- R8: An adjust strobe with adj_neg=1 subtracts cmd_sec and cmd_sub from the time. If the sub-second difference would be negative, it is wrapped by adding limit+1 and one more second is taken away.
- R9: A load or adjust strobe takes priority over the accumulator step. The step due in that cycle is dropped.
- R10: The seconds count is 32 bits and wraps from 0xFFFFFFFF to 0.
- R11: A write with wr_en=1 updates one register at the next edge, and the new value governs counting from the following cycle. wr_sel selects the register: 0 is the rate word, 1 is the step size, 2 is the mode (bit 0 of wr_data). wr_sel 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PTP reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write enable |
| wr_sel | input | 2 | Register select: 0 rate word, 1 step, 2 mode, 3 none |
| wr_data | input | 32 | Configuration write data |
| init_stb | input | 1 | Load time strobe |
| adj_stb | input | 1 | Adjust time strobe |
| adj_neg | input | 1 | Adjust direction: 1 subtract, 0 add |
| cmd_sec | input | 32 | Seconds operand for load or adjust |
| cmd_sub | input | 32 | Sub-second operand for load or adjust |
| sec_o | output | 32 | Current seconds |
| sub_o | output | 32 | Current sub-seconds |

## Verification
Several properties are checked on every cycle. The time holds when there is no carry and no strobe. A carry adds exactly the step when no rollover occurs. A load strobe places its operands in the time. A rate-word write lands in the register at the next edge, and reset clears the time. The rollover arithmetic in both modes, the borrow on subtraction, seconds wrap, the dropped step under strobe priority, and the exact one-step-per-two-cycles rate at mid-range can only be shown by the bench's directed scenarios, which compare against values worked out by hand.

// File: rtl/ptp_fine_clock_pkg.sv
package ptp_fine_clock_pkg;

    localparam int SEC_W = 32;
    localparam int SUB_W = 32;
    localparam int ACC_W = 32;
    localparam int DAT_W = 32;

    localparam logic [SUB_W-1:0] NS_MAX  = SUB_W'(999_999_999);
    localparam logic [SUB_W-1:0] BIN_MAX = {1'b0, {(SUB_W-1){1'b1}}};

    typedef enum logic [1:0] {
        SEL_RATE = 2'd0,
        SEL_STEP = 2'd1,
        SEL_MODE = 2'd2,
        SEL_NONE = 2'd3
    } wr_sel_e;

    typedef enum logic {
        ROLL_BIN = 1'b0,
        ROLL_NS  = 1'b1
    } roll_e;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
    } ptime_t;

    typedef struct packed {
        logic [ACC_W-1:0] rate;
        logic [SUB_W-1:0] step;
        roll_e            mode;
    } cfg_t;

    function automatic logic [SUB_W-1:0] sub_limit(roll_e m);
        return (m == ROLL_NS) ? NS_MAX : BIN_MAX;
    endfunction

    // Add a (seconds, sub-seconds) amount with rollover into seconds.
    function automatic ptime_t time_plus(ptime_t t, ptime_t d, roll_e m);
        ptime_t       r;
        logic [SUB_W:0] s;
        logic [SUB_W:0] lim;
        s   = {1'b0, t.sub} + {1'b0, d.sub};
        lim = {1'b0, sub_limit(m)};
        if (s > lim) begin
            r.sub = SUB_W'(s - lim - 1'b1);
            r.sec = t.sec + d.sec + 1'b1;
        end else begin
            r.sub = SUB_W'(s);
            r.sec = t.sec + d.sec;
        end
        return r;
    endfunction

    // Subtract a (seconds, sub-seconds) amount with borrow from seconds.
    function automatic ptime_t time_minus(ptime_t t, ptime_t d, roll_e m);
        ptime_t       r;
        logic [SUB_W:0] lim;
        lim = {1'b0, sub_limit(m)};
        if (t.sub >= d.sub) begin
            r.sub = t.sub - d.sub;
            r.sec = t.sec - d.sec;
        end else begin
            r.sub = SUB_W'({1'b0, t.sub} + lim + 1'b1 - {1'b0, d.sub});
            r.sec = t.sec - d.sec - 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/ptp_cfg_regs.sv
module ptp_cfg_regs
    import ptp_fine_clock_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [DAT_W-1:0] wr_data,
    output cfg_t             cfg
);

    wr_sel_e sel;
    assign sel = wr_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.rate <= '0;
            cfg.step <= '0;
            cfg.mode <= ROLL_BIN;
        end else if (wr_en) begin
            case (sel)
                SEL_RATE: cfg.rate <= ACC_W'(wr_data);
                SEL_STEP: cfg.step <= SUB_W'(wr_data);
                SEL_MODE: cfg.mode <= roll_e'(wr_data[0]);
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/ptp_rate_accum.sv
module ptp_rate_accum
    import ptp_fine_clock_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] rate,
    output logic             carry
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum   = {1'b0, acc_q} + {1'b0, rate};
    assign carry = sum[ACC_W];

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= sum[ACC_W-1:0];
    end

endmodule

// File: rtl/ptp_time_next.sv
module ptp_time_next
    import ptp_fine_clock_pkg::*;
(
    input  ptime_t cur,
    input  cfg_t   cfg,
    input  logic   carry,
    input  logic   init_stb,
    input  logic   adj_stb,
    input  logic   adj_neg,
    input  ptime_t cmd,
    output ptime_t nxt
);

    ptime_t step_amt;
    assign step_amt.sec = '0;
    assign step_amt.sub = cfg.step;

    always_comb begin
        nxt = cur;
        if (init_stb) begin
            nxt = cmd;
        end else if (adj_stb) begin
            if (adj_neg) nxt = time_minus(cur, cmd, cfg.mode);
            else         nxt = time_plus(cur, cmd, cfg.mode);
        end else if (carry) begin
            nxt = time_plus(cur, step_amt, cfg.mode);
        end
    end

endmodule

// File: rtl/ptp_fine_clock.sv
module ptp_fine_clock
    import ptp_fine_clock_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [DAT_W-1:0] wr_data,
    input  logic             init_stb,
    input  logic             adj_stb,
    input  logic             adj_neg,
    input  logic [SEC_W-1:0] cmd_sec,
    input  logic [SUB_W-1:0] cmd_sub,
    output logic [SEC_W-1:0] sec_o,
    output logic [SUB_W-1:0] sub_o
);

    cfg_t   cfg;
    logic   acc_carry;
    ptime_t now_q;
    ptime_t now_d;
    ptime_t cmd;

    assign cmd.sec = cmd_sec;
    assign cmd.sub = cmd_sub;

    ptp_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    ptp_rate_accum u_acc (
        .clk   (clk),
        .rst   (rst),
        .rate  (cfg.rate),
        .carry (acc_carry)
    );

    ptp_time_next u_next (
        .cur      (now_q),
        .cfg      (cfg),
        .carry    (acc_carry),
        .init_stb (init_stb),
        .adj_stb  (adj_stb),
        .adj_neg  (adj_neg),
        .cmd      (cmd),
        .nxt      (now_d)
    );

    always_ff @(posedge clk) begin
        if (rst) now_q <= '0;
        else     now_q <= now_d;
    end

    assign sec_o = now_q.sec;
    assign sub_o = now_q.sub;

endmodule

// File: rtl/ptp_fine_clock_chk.sv
module ptp_fine_clock_chk
    import ptp_fine_clock_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [DAT_W-1:0] wr_data,
    input logic             init_stb,
    input logic             adj_stb,
    input logic [SEC_W-1:0] cmd_sec,
    input logic [SUB_W-1:0] cmd_sub,
    input logic             carry,
    input cfg_t             cfg,
    input logic [SEC_W-1:0] sec_o,
    input logic [SUB_W-1:0] sub_o
);

    logic no_roll;
    assign no_roll = ({1'b0, sub_o} + {1'b0, cfg.step}) <= {1'b0, sub_limit(cfg.mode)};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (sec_o == '0 && sub_o == '0));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!carry && !init_stb && !adj_stb) |=> ($stable(sec_o) && $stable(sub_o)));

    // R2
    step_add_chk: assert property (@(posedge clk) disable iff (rst)
        (carry && !init_stb && !adj_stb && no_roll)
        |=> (sub_o == $past(sub_o) + $past(cfg.step) && $stable(sec_o)));

    // R6
    init_load_chk: assert property (@(posedge clk) disable iff (rst)
        init_stb |=> (sec_o == $past(cmd_sec) && sub_o == $past(cmd_sub)));

    // R11
    rate_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0) |=> (cfg.rate == $past(wr_data)));

endmodule

bind ptp_fine_clock ptp_fine_clock_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .init_stb (init_stb),
    .adj_stb  (adj_stb),
    .cmd_sec  (cmd_sec),
    .cmd_sub  (cmd_sub),
    .carry    (acc_carry),
    .cfg      (cfg),
    .sec_o    (sec_o),
    .sub_o    (sub_o)
);

// File: tb/ptp_fine_clock_test.sv
module ptp_fine_clock_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        init_stb = 1'b0;
    logic        adj_stb = 1'b0;
    logic        adj_neg = 1'b0;
    logic [31:0] cmd_sec = '0;
    logic [31:0] cmd_sub = '0;
    logic [31:0] sec_o;
    logic [31:0] sub_o;

    int n_checks = 0;
    int n_fail = 0;

    localparam logic [1:0] W_RATE = 2'd0;
    localparam logic [1:0] W_STEP = 2'd1;
    localparam logic [1:0] W_MODE = 2'd2;
    localparam logic [1:0] W_NONE = 2'd3;
    localparam logic [31:0] HALF = 32'h8000_0000;

    always #4 clk = ~clk;

    ptp_fine_clock uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .init_stb(init_stb), .adj_stb(adj_stb), .adj_neg(adj_neg),
        .cmd_sec(cmd_sec), .cmd_sub(cmd_sub), .sec_o(sec_o), .sub_o(sub_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d (0x%08h) expected %0d (0x%08h)", tag, got, got, exp, exp);
        end
    endtask

    task automatic check_time(input string tag, input logic [31:0] es, input logic [31:0] ess);
        check({tag, " sec"}, sec_o, es);
        check({tag, " sub"}, sub_o, ess);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [31:0] s, input logic [31:0] ss);
        @(negedge clk);
        init_stb = 1'b1; cmd_sec = s; cmd_sub = ss;
        @(negedge clk);
        init_stb = 1'b0;
    endtask

    task automatic adjust(input logic neg, input logic [31:0] s, input logic [31:0] ss);
        @(negedge clk);
        adj_stb = 1'b1; adj_neg = neg; cmd_sec = s; cmd_sub = ss;
        @(negedge clk);
        adj_stb = 1'b0;
    endtask

    // Runs exactly 2*n edges with rate word 0x80000000, then halts.
    task automatic run_pairs(input int n);
        wr(W_RATE, HALF);
        repeat (2 * n - 1) @(posedge clk);
        wr(W_RATE, 32'h0);
    endtask

    task automatic t_reset;
        check_time("R1 reset", 32'd0, 32'd0);
        repeat (10) @(negedge clk);
        check_time("R1/R3 halted after reset", 32'd0, 32'd0);
    endtask

    task automatic t_count;
        wr(W_STEP, 32'd20);
        wr(W_MODE, 32'd1);
        load(32'd7, 32'd0);
        check_time("R6 load", 32'd7, 32'd0);
        run_pairs(5);
        check_time("R2 five steps", 32'd7, 32'd100);
        repeat (6) @(negedge clk);
        check_time("R3 hold without carry", 32'd7, 32'd100);
    endtask

    task automatic t_ns_roll;
        load(32'd3, 32'd999_999_995);
        run_pairs(1);
        check_time("R4 ns rollover", 32'd4, 32'd15);
    endtask

    task automatic t_bin_roll;
        wr(W_MODE, 32'd0);
        wr(W_STEP, 32'h20);
        load(32'd9, 32'h7FFF_FFF0);
        run_pairs(1);
        check_time("R5 binary rollover", 32'd10, 32'h10);
    endtask

    task automatic t_sec_wrap;
        load(32'hFFFF_FFFF, 32'h7FFF_FFFF);
        run_pairs(1);
        check_time("R10 seconds wrap", 32'd0, 32'h1F);
    endtask

    task automatic t_adjust;
        wr(W_MODE, 32'd1);
        load(32'd100, 32'd999_999_990);
        adjust(1'b0, 32'd2, 32'd20);
        check_time("R7 add with carry", 32'd103, 32'd10);
        adjust(1'b1, 32'd1, 32'd15);
        check_time("R8 subtract with borrow ns", 32'd101, 32'd999_999_995);
        wr(W_MODE, 32'd0);
        load(32'd50, 32'd3);
        adjust(1'b1, 32'd0, 32'd5);
        check_time("R8 subtract with borrow binary", 32'd49, 32'h7FFF_FFFE);
        adjust(1'b0, 32'd5, 32'd100);
        check_time("R7 add with carry binary", 32'd55, 32'd98);
    endtask

    task automatic t_priority;
        wr(W_MODE, 32'd1);
        wr(W_STEP, 32'd20);
        load(32'd0, 32'd0);
        wr(W_RATE, HALF);          // edge e: accumulator still at zero
        @(negedge clk);            // edge e+1: no carry
        init_stb = 1'b1; cmd_sec = 32'd1000; cmd_sub = 32'd500;
        @(negedge clk);            // edge e+2: carry coincides with load
        init_stb = 1'b0;
        check_time("R9 load wins over step", 32'd1000, 32'd500);
        wr(W_RATE, 32'h0);         // edge e+3 no carry, e+4 carry
        check_time("R9/R2 stepping resumes", 32'd1000, 32'd520);
    endtask

    task automatic t_regs;
        wr(W_MODE, 32'd0);
        wr(W_STEP, 32'd7);
        wr(W_NONE, 32'h0000_0055);
        load(32'd0, 32'd999_999_995);
        run_pairs(2);
        check_time("R11 select 3 ignored", 32'd0, 32'd1_000_000_009);
        wr(W_STEP, 32'd1);
        run_pairs(1);
        check_time("R11 new step used", 32'd0, 32'd1_000_000_010);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_count();
        t_ns_roll();
        t_bin_roll();
        t_sec_wrap();
        t_adjust();
        t_priority();
        t_regs();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule